// File: doc/BRIEF.md
# Cache RAM Debug Readout Controller

This block lets privileged software look at raw entries of a core's level-1 data cache, level-1 instruction cache and translation cache. Each of these three structures has a tag half and a data half, so there are six arrays in all. Software picks one of them by writing a location word to one of six write-only trigger registers. The controller then makes exactly one synchronous read of that array. It splits the returned word across three read-only 64-bit result registers, which software reads afterwards. The arrays sit outside the block. Each one is reached through a plain read port with a one-hot enable and a shared way, index and offset bus.

All nine registers can be reached in two ways: a 64-bit system-register encoding and a 32-bit coprocessor encoding. Both decode to the same storage. An access succeeds only at the highest exception level, and only in the register's own direction. Any other access to a register of this set raises an undefined-instruction indication and changes nothing. While a readout is in flight the block reports busy. Any well-formed access during that time waits with its ready output low.

Top module: `ramdump_ctrl`

## Requirements
- R1: A register of the set is addressed when op1=6, CRn=15 and op2 is 0, 1 or 2. CRm=0 selects result register op2. CRm=2 selects the tag trigger of the array op2, where 0 is the data cache, 1 the instruction cache and 2 the translation cache. CRm=4 selects the data trigger of the same array. In the 64-bit form (acc_form32=0), op0 must be 3 for result registers and 1 for triggers. In the 32-bit form, the coprocessor number must be 15. Both forms reach the same registers.
- R2: An addressed access made with acc_el other than 3 completes in the same cycle with acc_undef high and acc_rdata zero. It starts no array read and changes no register.
- R3: A read of a trigger or a write of a result register completes with acc_undef high. It starts no array read and changes no register.
- R4: An accepted trigger write drives arr_rd_en one-hot, for exactly one cycle, in the cycle after acceptance. The bit position is the array number: 0 data-cache tag, 1 instruction-cache tag, 2 translation tag, 3 data-cache data, 4 instruction-cache data, 5 translation data. At the same time the block drives arr_way=wdata[31:30] and arr_idx=wdata[13:6]. It drives arr_off=wdata[5:3] for the two cache data arrays and zero for the other four.
- R5: busy is high from the cycle after an accepted trigger write for RD_LAT+1 cycles. During that time every addressed, non-faulting access is held off with acc_ready low.
- R6: The captured word is placed least-significant part first: bits [63:0] go to result 0, [127:64] to result 1 and [191:128] to result 2. Bits above the array's width read as zero. The default widths are 48, 40, 96, 64, 128 and 192 for arrays 0 to 5.
- R7: An index or way beyond the array's size issues no array read and captures all-zero data. The default sizes are: data cache 256 sets × 4 ways, instruction cache 128 × 2, translation cache 64 × 4.
- R8: The result registers are zero after reset. They keep their contents until the capture of a readout completes.
- R9: An access that matches no encoding of R1 completes at once, with acc_undef low and acc_rdata zero, and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_form32 | input | 1 | 1 = 32-bit coprocessor form, 0 = 64-bit system-register form |
| acc_op0 | input | 2 | op0 field (64-bit form only) |
| acc_cpnum | input | 4 | Coprocessor number (32-bit form only) |
| acc_op1 | input | 3 | op1 field |
| acc_crn | input | 4 | CRn field |
| acc_crm | input | 4 | CRm field |
| acc_op2 | input | 3 | op2 field |
| acc_el | input | 2 | Current exception level |
| acc_wdata | input | 64 | Write data (location word) |
| acc_ready | output | 1 | Access completes this cycle |
| acc_rdata | output | 64 | Read data |
| acc_undef | output | 1 | Undefined-instruction indication for this access |
| busy | output | 1 | Readout in flight |
| arr_rd_en | output | 6 | One-hot array read enable |
| arr_way | output | 2 | Way to read |
| arr_idx | output | 8 | Set or entry index |
| arr_off | output | 3 | Word offset for cache data arrays |
| arr_rdata | input | 6x192 | Read data from each array, valid RD_LAT cycles after its enable |

## Verification
An accepted trigger write is the rising clock edge E0. The enable and the location bus are due in the cycle after E0. busy holds through the edge E0+RD_LAT+1, and the new result is readable from the cycle after that edge. The undefined-instruction indication, the ready signal and the read data are combinational, so they are due in the same cycle as the request. The bench drives on falling edges and samples one time unit after them. It checks the enable and busy on each cycle after E0. It starts a read right after a trigger, so the stall is seen on every cycle until the capture.

// File: rtl/ramdump_pkg.sv
package ramdump_pkg;
  localparam int REG_W    = 64;
  localparam int N_RES    = 3;
  localparam int WORD_W   = REG_W * N_RES;
  localparam int N_ARR    = 6;
  localparam int WAY_W    = 2;
  localparam int IDX_W    = 8;
  localparam int OFF_W    = 3;
  localparam int ARR_SEL_W = $clog2(N_ARR);

  // location word layout
  localparam int WAY_LSB = 30;
  localparam int IDX_LSB = 6;
  localparam int OFF_LSB = 3;

  typedef enum logic [ARR_SEL_W-1:0] {
    ARR_DTAG = 3'd0,
    ARR_ITAG = 3'd1,
    ARR_TTAG = 3'd2,
    ARR_DDAT = 3'd3,
    ARR_IDAT = 3'd4,
    ARR_TDAT = 3'd5
  } arr_sel_e;

  function automatic logic [WORD_W-1:0] width_mask(input int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (b < w) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ramdump_decode.sv
module ramdump_decode
  import ramdump_pkg::*;
(
  input  logic                 form32,
  input  logic [1:0]           op0,
  input  logic [3:0]           cpnum,
  input  logic [2:0]           op1,
  input  logic [3:0]           crn,
  input  logic [3:0]           crm,
  input  logic [2:0]           op2,
  input  logic                 write,
  input  logic [1:0]           el,
  output logic                 hit,
  output logic                 fault,
  output logic                 is_trig,
  output logic [ARR_SEL_W-1:0] arr_sel,
  output logic [1:0]           res_sel
);
  logic grp_ok, is_res, form_ok, bad_dir;

  always_comb begin
    grp_ok  = (op1 == 3'd6) && (crn == 4'd15) && (op2 < 3'd3);
    is_res  = (crm == 4'd0);
    is_trig = (crm == 4'd2) || (crm == 4'd4);
    if (form32) form_ok = (cpnum == 4'd15);
    else        form_ok = is_res ? (op0 == 2'd3) : (op0 == 2'd1);
    hit     = grp_ok && (is_res || is_trig) && form_ok;
    bad_dir = is_res ? write : !write;
    fault   = hit && ((el != 2'd3) || bad_dir);
    arr_sel = (crm == 4'd4) ? (op2 + 3'd3) : op2;
    res_sel = op2[1:0];
  end
endmodule

// File: rtl/ramdump_seq.sv
module ramdump_seq
  import ramdump_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_ok,
  input  logic [ARR_SEL_W-1:0] start_sel,
  input  logic [WAY_W-1:0]     start_way,
  input  logic [IDX_W-1:0]     start_idx,
  input  logic [OFF_W-1:0]     start_off,
  output logic                 busy,
  output logic [N_ARR-1:0]     rd_en,
  output logic [WAY_W-1:0]     rd_way,
  output logic [IDX_W-1:0]     rd_idx,
  output logic [OFF_W-1:0]     rd_off,
  output logic                 cap,
  output logic                 cap_ok,
  output logic [ARR_SEL_W-1:0] cap_sel
);
  localparam int CNT_W = $clog2(RD_LAT + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RD_LAT + 1);

  logic                 busy_q, busy_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 cnt_en;
  logic [N_ARR-1:0]     en_q, en_n;
  logic                 ok_q;
  logic [ARR_SEL_W-1:0] sel_q;
  logic [WAY_W-1:0]     way_q;
  logic [IDX_W-1:0]     idx_q;
  logic [OFF_W-1:0]     off_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    en_n   = '0;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_LOAD;
      cnt_en = 1'b1;
      if (start_ok) en_n = N_ARR'(1) << start_sel;
    end else if (busy_q) begin
      cnt_n  = cnt_q - 1'b1;
      cnt_en = 1'b1;
      if (cnt_q == CNT_W'(1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      en_q   <= '0;
    end else begin
      busy_q <= busy_n;
      en_q   <= en_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      sel_q <= '0;
      way_q <= '0;
      idx_q <= '0;
      off_q <= '0;
    end else if (start) begin
      ok_q  <= start_ok;
      sel_q <= start_sel;
      way_q <= start_way;
      idx_q <= start_idx;
      off_q <= start_off;
    end
  end

  assign busy    = busy_q;
  assign rd_en   = en_q;
  assign rd_way  = way_q;
  assign rd_idx  = idx_q;
  assign rd_off  = off_q;
  assign cap     = busy_q && (cnt_q == CNT_W'(1));
  assign cap_ok  = ok_q;
  assign cap_sel = sel_q;
endmodule

// File: rtl/ramdump_capture.sv
module ramdump_capture
  import ramdump_pkg::*;
#(
  parameter int W_DTAG = 48,
  parameter int W_ITAG = 40,
  parameter int W_TTAG = 96,
  parameter int W_DDAT = 64,
  parameter int W_IDAT = 128,
  parameter int W_TDAT = 192
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap,
  input  logic                              cap_ok,
  input  logic [ARR_SEL_W-1:0]              cap_sel,
  input  logic [N_ARR-1:0][WORD_W-1:0]      arr_rdata,
  output logic [N_RES-1:0][REG_W-1:0]       res
);
  localparam int WIDTHS [N_ARR] = '{W_DTAG, W_ITAG, W_TTAG, W_DDAT, W_IDAT, W_TDAT};

  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int k = 0; k < N_ARR; k++) begin
      if (cap_ok && (cap_sel == ARR_SEL_W'(k)))
        word = arr_rdata[k] & width_mask(WIDTHS[k]);
    end
  end

  for (genvar g = 0; g < N_RES; g++) begin : g_res
    logic [REG_W-1:0] res_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q <= '0;
      else if (cap) res_q <= word[g*REG_W +: REG_W];
    end
    assign res[g] = res_q;
  end
endmodule

// File: rtl/ramdump_ctrl.sv
module ramdump_ctrl
  import ramdump_pkg::*;
#(
  parameter int RD_LAT    = 1,
  parameter int DC_SETS   = 256,
  parameter int DC_WAYS   = 4,
  parameter int IC_SETS   = 128,
  parameter int IC_WAYS   = 2,
  parameter int TLB_SETS  = 64,
  parameter int TLB_WAYS  = 4,
  parameter int W_DTAG    = 48,
  parameter int W_ITAG    = 40,
  parameter int W_TTAG    = 96,
  parameter int W_DDAT    = 64,
  parameter int W_IDAT    = 128,
  parameter int W_TDAT    = 192
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic                          acc_form32,
  input  logic [1:0]                    acc_op0,
  input  logic [3:0]                    acc_cpnum,
  input  logic [2:0]                    acc_op1,
  input  logic [3:0]                    acc_crn,
  input  logic [3:0]                    acc_crm,
  input  logic [2:0]                    acc_op2,
  input  logic [1:0]                    acc_el,
  input  logic [63:0]                   acc_wdata,
  output logic                          acc_ready,
  output logic [63:0]                   acc_rdata,
  output logic                          acc_undef,
  output logic                          busy,
  output logic [5:0]                    arr_rd_en,
  output logic [1:0]                    arr_way,
  output logic [7:0]                    arr_idx,
  output logic [2:0]                    arr_off,
  input  logic [5:0][191:0]             arr_rdata
);
  logic                 dec_hit, dec_fault, dec_trig;
  logic [ARR_SEL_W-1:0] dec_sel;
  logic [1:0]           dec_res;
  logic [WAY_W-1:0]     loc_way;
  logic [IDX_W-1:0]     loc_idx;
  logic [OFF_W-1:0]     loc_off;
  logic                 loc_ok, start;
  logic                 cap, cap_ok;
  logic [ARR_SEL_W-1:0] cap_sel;
  logic [N_RES-1:0][REG_W-1:0] res;

  ramdump_decode u_dec (
    .form32 (acc_form32), .op0(acc_op0), .cpnum(acc_cpnum), .op1(acc_op1),
    .crn    (acc_crn), .crm(acc_crm), .op2(acc_op2), .write(acc_write),
    .el     (acc_el), .hit(dec_hit), .fault(dec_fault), .is_trig(dec_trig),
    .arr_sel(dec_sel), .res_sel(dec_res)
  );

  always_comb begin
    loc_way = acc_wdata[WAY_LSB +: WAY_W];
    loc_idx = acc_wdata[IDX_LSB +: IDX_W];
    loc_off = ((dec_sel == ARR_DDAT) || (dec_sel == ARR_IDAT)) ?
              acc_wdata[OFF_LSB +: OFF_W] : '0;
    unique case (dec_sel)
      ARR_DTAG, ARR_DDAT: loc_ok = (int'(loc_idx) < DC_SETS)  && (int'(loc_way) < DC_WAYS);
      ARR_ITAG, ARR_IDAT: loc_ok = (int'(loc_idx) < IC_SETS)  && (int'(loc_way) < IC_WAYS);
      ARR_TTAG, ARR_TDAT: loc_ok = (int'(loc_idx) < TLB_SETS) && (int'(loc_way) < TLB_WAYS);
      default:            loc_ok = 1'b0;
    endcase
  end

  always_comb begin
    acc_ready = !(dec_hit && !dec_fault && busy);
    acc_undef = acc_valid && dec_hit && dec_fault;
    start     = acc_valid && acc_ready && dec_hit && !dec_fault && dec_trig;
    acc_rdata = '0;
    if (acc_valid && acc_ready && dec_hit && !dec_fault && !dec_trig && (dec_res < 2'd3))
      acc_rdata = res[dec_res];
  end

  ramdump_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ok(loc_ok),
    .start_sel(dec_sel), .start_way(loc_way), .start_idx(loc_idx),
    .start_off(loc_off), .busy(busy), .rd_en(arr_rd_en), .rd_way(arr_way),
    .rd_idx(arr_idx), .rd_off(arr_off), .cap(cap), .cap_ok(cap_ok),
    .cap_sel(cap_sel)
  );

  ramdump_capture #(
    .W_DTAG(W_DTAG), .W_ITAG(W_ITAG), .W_TTAG(W_TTAG),
    .W_DDAT(W_DDAT), .W_IDAT(W_IDAT), .W_TDAT(W_TDAT)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_ok(cap_ok),
    .cap_sel(cap_sel), .arr_rdata(arr_rdata), .res(res)
  );
endmodule

// File: rtl/ramdump_ctrl_chk.sv
module ramdump_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_valid,
  input logic         acc_ready,
  input logic         acc_undef,
  input logic         dec_hit,
  input logic         dec_fault,
  input logic         busy,
  input logic [5:0]   arr_rd_en,
  input logic [191:0] res_flat
);
  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid && dec_hit && !dec_fault) |-> !acc_ready);

  // R2
  fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> (arr_rd_en == 6'd0));

  // R3
  fault_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> acc_ready);

  // R4
  single_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arr_rd_en));

  // R4
  enable_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_en != 6'd0) |-> busy);

  // R4
  enable_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_en != 6'd0) |=> (arr_rd_en == 6'd0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(res_flat));
endmodule

bind ramdump_ctrl ramdump_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_undef (acc_undef),
  .dec_hit   (dec_hit),
  .dec_fault (dec_fault),
  .busy      (busy),
  .arr_rd_en (arr_rd_en),
  .res_flat  (res)
);

// File: tb/ramdump_ctrl_tb_top.sv
module ramdump_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic acc_valid, acc_write, acc_form32;
  logic [1:0] acc_op0, acc_el;
  logic [3:0] acc_cpnum, acc_crn, acc_crm;
  logic [2:0] acc_op1, acc_op2;
  logic [63:0] acc_wdata, acc_rdata;
  logic acc_ready, acc_undef, busy;
  logic [5:0] arr_rd_en;
  logic [1:0] arr_way;
  logic [7:0] arr_idx;
  logic [2:0] arr_off;
  logic [5:0][191:0] mrd;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  ramdump_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_form32(acc_form32), .acc_op0(acc_op0), .acc_cpnum(acc_cpnum),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_el(acc_el), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .acc_rdata(acc_rdata), .acc_undef(acc_undef), .busy(busy),
    .arr_rd_en(arr_rd_en), .arr_way(arr_way), .arr_idx(arr_idx),
    .arr_off(arr_off), .arr_rdata(mrd)
  );

  // array content model: each entry has a distinct pattern
  function automatic logic [191:0] pat(int a, int w, int i, int o);
    logic [191:0] r;
    for (int k = 0; k < 3; k++)
      r[k*64 +: 64] = (64'(a) << 56) | (64'(k) << 48) | (64'(w) << 40) |
                      (64'(i) << 16) | (64'(o) << 8) | 64'h5A;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    for (int a = 0; a < 6; a++)
      if (arr_rd_en[a]) mrd[a] <= pat(a, arr_way, arr_idx, arr_off);
  end

  // expected values from the requirements (R6, R7)
  function automatic logic [191:0] expect_word(int a, int w, int i, int o);
    int wid, sets, ways;
    logic [191:0] m;
    case (a)
      0: wid = 48;  1: wid = 40;  2: wid = 96;
      3: wid = 64;  4: wid = 128; default: wid = 192;
    endcase
    case (a % 3)
      0: begin sets = 256; ways = 4; end
      1: begin sets = 128; ways = 2; end
      default: begin sets = 64; ways = 4; end
    endcase
    if (i >= sets || w >= ways) return '0;
    m = '0;
    for (int b = 0; b < 192; b++) if (b < wid) m[b] = 1'b1;
    return pat(a, w, i, (a == 3 || a == 4) ? o : 0) & m;
  endfunction

  function automatic logic in_range(int a, int w, int i);
    return expect_word(a, w, i, 0) != '0;
  endfunction

  task automatic chk(string req, string what, logic [191:0] act, logic [191:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_form32 = 0; acc_op0 = 0; acc_cpnum = 0;
    acc_op1 = 0; acc_crn = 0; acc_crm = 0; acc_op2 = 0; acc_el = 2'd3; acc_wdata = 0;
  endtask

  // R1: set up a well-formed encoding in either form
  task automatic set_acc(bit f32, bit wr, int crm, int op2, logic [1:0] el, logic [63:0] wd);
    acc_valid = 1; acc_write = wr; acc_form32 = f32;
    acc_op0 = (crm == 0) ? 2'd3 : 2'd1; acc_cpnum = 4'd15;
    acc_op1 = 3'd6; acc_crn = 4'd15; acc_crm = 4'(crm); acc_op2 = 3'(op2);
    acc_el = el; acc_wdata = wd;
  endtask

  // issue a trigger write; returns at the falling edge after the accepting edge
  task automatic trig(bit f32, int a, logic [63:0] wd);
    @(negedge clk);
    set_acc(f32, 1, (a < 3) ? 2 : 4, a % 3, 2'd3, wd);
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    idle();
  endtask

  task automatic rd(bit f32, int r, output logic [63:0] v);
    @(negedge clk);
    set_acc(f32, 0, 0, r, 2'd3, 64'd0);
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    v = acc_rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic read_all(string req, logic [191:0] exp);
    logic [63:0] v;
    for (int r = 0; r < 3; r++) begin
      rd(r[0], r, v);
      chk(req, $sformatf("result%0d", r), 192'(v), 192'(exp[r*64 +: 64]));
    end
  endtask

  // vector table: {form32, array, way, idx, off}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'd0, 2'd1, 8'd5,   3'd0},
    {1'b1, 3'd1, 2'd1, 8'd100, 3'd0},
    {1'b0, 3'd2, 2'd3, 8'd63,  3'd0},
    {1'b1, 3'd3, 2'd2, 8'd255, 3'd7},
    {1'b0, 3'd4, 2'd0, 8'd127, 3'd4},
    {1'b1, 3'd5, 2'd3, 8'd10,  3'd0},
    {1'b0, 3'd4, 2'd0, 8'd128, 3'd1},
    {1'b1, 3'd1, 2'd2, 8'd3,   3'd0},
    {1'b0, 3'd5, 2'd0, 8'd64,  3'd0},
    {1'b0, 3'd3, 2'd3, 8'd0,   3'd1}
  };

  function automatic logic [63:0] loc(int w, int i, int o);
    return 64'hDEAD_0000_0010_0005 | (64'(w) << 30) | (64'(i) << 6) | (64'(o) << 3);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      n_fail++; n_run++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [191:0] last;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R8 reset state
    chk("R8", "busy after reset", 192'(busy), 192'(0));
    chk("R4", "enable after reset", 192'(arr_rd_en), 192'(0));
    read_all("R8", '0);

    // table walk: R1 R4 R5 R6 R7
    for (int n = 0; n < NV; n++) begin
      bit f32; int a, w, i, o; logic [5:0] en_exp;
      f32 = VEC[n][16]; a = VEC[n][15:13]; w = VEC[n][12:11];
      i = VEC[n][10:3]; o = VEC[n][2:0];
      trig(f32, a, loc(w, i, o));
      #1;
      en_exp = in_range(a, w, i) ? (6'd1 << a) : 6'd0;
      chk("R7", $sformatf("v%0d enable", n), 192'(arr_rd_en), 192'(en_exp));
      chk("R5", $sformatf("v%0d busy E0+1", n), 192'(busy), 192'(1));
      if (en_exp != 0) begin
        chk("R4", $sformatf("v%0d way", n), 192'(arr_way), 192'(w));
        chk("R4", $sformatf("v%0d idx", n), 192'(arr_idx), 192'(i));
        chk("R4", $sformatf("v%0d off", n), 192'(arr_off), 192'((a == 3 || a == 4) ? o : 0));
      end
      @(negedge clk); #1;
      chk("R4", $sformatf("v%0d enable drop", n), 192'(arr_rd_en), 192'(0));
      chk("R5", $sformatf("v%0d busy E1+", n), 192'(busy), 192'(1));
      @(negedge clk); #1;
      chk("R5", $sformatf("v%0d busy end", n), 192'(busy), 192'(0));
      read_all((en_exp != 0) ? "R6" : "R7", expect_word(a, w, i, o));
    end
    last = expect_word(3, 3, 0, 1);

    // R5 stall of a read started right after a trigger
    trig(1'b0, 2, loc(1, 20, 0));
    set_acc(1'b0, 0, 0, 1, 2'd3, 0);
    #1;
    chk("R5", "ready while busy 1", 192'(acc_ready), 192'(0));
    @(negedge clk); #1;
    chk("R5", "ready while busy 2", 192'(acc_ready), 192'(0));
    @(negedge clk); #1;
    chk("R5", "ready after capture", 192'(acc_ready), 192'(1));
    chk("R6", "stalled read data", 192'(acc_rdata), 192'(expect_word(2, 1, 20, 0)[127:64]));
    @(negedge clk); idle();
    last = expect_word(2, 1, 20, 0);

    // R2 trigger below EL3
    @(negedge clk);
    set_acc(1'b1, 1, 4, 1, 2'd1, loc(0, 1, 1));
    #1;
    chk("R2", "undef low EL write", 192'(acc_undef), 192'(1));
    @(negedge clk); idle(); #1;
    chk("R2", "no enable", 192'(arr_rd_en), 192'(0));
    chk("R2", "no busy", 192'(busy), 192'(0));
    // R2 read below EL3
    set_acc(1'b0, 0, 0, 0, 2'd2, 0);
    #1;
    chk("R2", "undef low EL read", 192'(acc_undef), 192'(1));
    chk("R2", "rdata zero", 192'(acc_rdata), 192'(0));
    @(negedge clk); idle();

    // R3 read of a trigger, write of a result
    set_acc(1'b0, 0, 2, 0, 2'd3, 0);
    acc_op0 = 2'd1;
    #1;
    chk("R3", "read of trigger undef", 192'(acc_undef), 192'(1));
    @(negedge clk); idle();
    set_acc(1'b1, 1, 0, 2, 2'd3, 64'hFFFF);
    #1;
    chk("R3", "write of result undef", 192'(acc_undef), 192'(1));
    @(negedge clk); idle(); #1;
    chk("R3", "no busy", 192'(busy), 192'(0));
    read_all("R3", last);

    // R9 non-matching encodings
    set_acc(1'b0, 1, 2, 0, 2'd3, loc(0, 0, 0));
    acc_op0 = 2'd3;
    #1;
    chk("R9", "wrong op0 undef", 192'(acc_undef), 192'(0));
    chk("R9", "wrong op0 ready", 192'(acc_ready), 192'(1));
    @(negedge clk); idle(); #1;
    chk("R9", "wrong op0 no busy", 192'(busy), 192'(0));
    set_acc(1'b1, 0, 0, 0, 2'd3, 0);
    acc_cpnum = 4'd14;
    #1;
    chk("R9", "wrong coproc rdata", 192'(acc_rdata), 192'(0));
    chk("R9", "wrong coproc undef", 192'(acc_undef), 192'(0));
    @(negedge clk); idle();
    set_acc(1'b0, 0, 0, 3, 2'd3, 0);
    #1;
    chk("R1", "op2=3 not addressed", 192'(acc_undef), 192'(0));
    @(negedge clk); idle();
    read_all("R9", last);

    // R8 reset clears captured results
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    read_all("R8", '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule